// File: doc/BRIEF.md
# In-memory row logic sequencer

This block models a small DRAM subarray together with the sequencer that turns whole-row logic requests into array primitives. The array holds user data rows, three scratch rows, two constant control rows (all zeros and all ones) and one row of dual-contact cells. The dual-contact row can be written through an inverting wordline. The array knows one primitive: it activates a first row (or the three scratch rows at once), activates a second row, and precharges. The second row takes the value latched from the first activation. When the three scratch rows open together, every bit resolves to the majority of the three values.

A request names an operation, two source rows and a destination row. The sequencer expands it into a fixed list of primitives and issues one per clock. AND and OR load the scratch rows, then fire a triple activation. NOT passes through the negation wordline. COPY is a single primitive. A done pulse marks the end of a request. A request whose destination is not a data row, or whose source indices fall outside the array, is refused with an error pulse. A plain host port loads and reads rows.

Requests use valid/ready. A request is taken on a rising edge where both are high. `req_ready` is low while a request runs, so the next request waits. The source must hold `req_valid` and the request fields steady until they are taken. Only one request is in flight at a time.

Top module: `bulk_row_engine`

## Requirements
- R1: After reset, every data, scratch and dual-contact row reads zero, the zeros row reads all zeros, the ones row reads all ones, `req_ready` is high and `done` and `err` are low.
- R2: Row indices map as follows: 0..NDATA-1 are data rows, NDATA..NDATA+2 are scratch rows 1..3, NDATA+3 is the zeros row, NDATA+4 is the ones row and NDATA+5 is the dual-contact row. `rd_data` shows the row chosen by `rd_idx` in the same cycle, and shows zero for an index beyond the array. A host write with `wr_en` changes only data rows; a host write that names any other row has no effect.
- R3: Opcodes are 0 COPY, 1 AND, 2 OR and 3 NOT. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. For an accepted request, `req_ready` is low in the cycle after that edge.
- R4: COPY writes source A into the destination, and `done` rises 1 clock edge after the accepting edge.
- R5: AND writes the bitwise AND of sources A and B into the destination. It does this as four primitives: A to scratch 1, B to scratch 2, the zeros row to scratch 3, and then a triple activation into the destination. `done` rises 4 edges after the accepting edge.
- R6: OR uses the same four-step sequence with the ones row in place of the zeros row. It writes A OR B into the destination, and `done` rises 4 edges after the accepting edge.
- R7: After an AND or OR, all three scratch rows hold the result.
- R8: NOT writes the complement of source A into the destination and leaves that complement in the dual-contact row. `done` rises 2 edges after the accepting edge.
- R9: `done` is high for exactly one cycle, and `req_ready` is high again in that cycle.
- R10: A request whose destination is not a data row, or whose source index is at or beyond NDATA+6, raises `err` for one cycle right after the accepting edge. It raises no `done` and changes no row.
- R11: The zeros and ones rows never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation code |
| req_src_a | input | IDX_W | First source row |
| req_src_b | input | IDX_W | Second source row (AND, OR) |
| req_dst | input | IDX_W | Destination row |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| wr_en | input | 1 | Host row write strobe |
| wr_idx | input | IDX_W | Host write row |
| wr_data | input | ROW_W | Host write value |
| rd_idx | input | IDX_W | Host read row |
| rd_data | output | ROW_W | Host read value |

## Verification
The bench builds the block with its defaults: 64-bit rows and 16 data rows. That gives 22 rows behind a 5-bit index, so codes 22 to 31 exist on the pins. This puts the out-of-range rejection within reach, along with reads of indices beyond the array. With 16 data rows there is room to chain results through several rows. The chain covers a source equal to the destination, a scratch row used as a source, and a NOT of the dual-contact row itself. Each of these shows whether the primitives land in the required order.

// File: rtl/rowop_pkg.sv
package rowop_pkg;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_AND  = 2'd1,
    OP_OR   = 2'd2,
    OP_NOT  = 2'd3
  } rop_e;

  // index of the final primitive for each operation
  function automatic logic [1:0] final_step(input rop_e op);
    case (op)
      OP_COPY: final_step = 2'd0;
      OP_NOT:  final_step = 2'd1;
      default: final_step = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/rowop_check.sv
module rowop_check #(
  parameter int unsigned NDATA = 16,
  parameter int unsigned IDX_W = 5
) (
  input  logic [1:0]       op,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic [IDX_W-1:0] dst,
  output logic             ok
);
  localparam int unsigned NROWS = NDATA + 6;

  logic uses_b;

  always_comb begin
    uses_b = (op == 2'd1) || (op == 2'd2);
    ok = (int'(dst) < int'(NDATA)) &&
         (int'(src_a) < int'(NROWS)) &&
         (!uses_b || (int'(src_b) < int'(NROWS)));
  end
endmodule

// File: rtl/rowop_seq.sv
module rowop_seq
  import rowop_pkg::*;
#(
  parameter int unsigned NDATA = 16,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_src_a,
  input  logic [IDX_W-1:0] req_src_b,
  input  logic [IDX_W-1:0] req_dst,
  input  logic             req_ok,
  output logic             prim_valid,
  output logic             prim_triple,
  output logic             prim_neg,
  output logic [IDX_W-1:0] prim_src,
  output logic [IDX_W-1:0] prim_dst,
  output logic             done,
  output logic             err
);
  localparam logic [IDX_W-1:0] SCR1 = IDX_W'(NDATA);
  localparam logic [IDX_W-1:0] SCR2 = IDX_W'(NDATA + 1);
  localparam logic [IDX_W-1:0] SCR3 = IDX_W'(NDATA + 2);
  localparam logic [IDX_W-1:0] ZROW = IDX_W'(NDATA + 3);
  localparam logic [IDX_W-1:0] OROW = IDX_W'(NDATA + 4);
  localparam logic [IDX_W-1:0] DROW = IDX_W'(NDATA + 5);

  logic             busy_q;
  logic [1:0]       step_q;
  rop_e             op_q;
  logic [IDX_W-1:0] a_q, b_q, d_q;
  logic             done_q, err_q;
  logic             last;

  assign req_ready = !busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign last      = (step_q == final_step(op_q));

  always_comb begin
    prim_valid  = busy_q;
    prim_triple = 1'b0;
    prim_neg    = 1'b0;
    prim_src    = a_q;
    prim_dst    = d_q;
    case (op_q)
      OP_COPY: ;
      OP_NOT: begin
        if (step_q == 2'd0) begin
          prim_neg = 1'b1;
          prim_dst = DROW;
        end else begin
          prim_src = DROW;
        end
      end
      default: begin
        case (step_q)
          2'd0: prim_dst = SCR1;
          2'd1: begin prim_src = b_q; prim_dst = SCR2; end
          2'd2: begin
            prim_src = (op_q == OP_AND) ? ZROW : OROW;
            prim_dst = SCR3;
          end
          default: begin prim_triple = 1'b1; prim_src = SCR1; end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= 2'd0;
      op_q   <= OP_COPY;
      a_q    <= '0;
      b_q    <= '0;
      d_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          if (req_ok) begin
            busy_q <= 1'b1;
            step_q <= 2'd0;
            op_q   <= rop_e'(req_op);
            a_q    <= req_src_a;
            b_q    <= req_src_b;
            d_q    <= req_dst;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else begin
        step_q <= step_q + 2'd1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/row_array.sv
module row_array #(
  parameter int unsigned ROW_W = 64,
  parameter int unsigned NDATA = 16,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prim_valid,
  input  logic             prim_triple,
  input  logic             prim_neg,
  input  logic [IDX_W-1:0] prim_src,
  input  logic [IDX_W-1:0] prim_dst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ROW_W-1:0] rd_data,
  output logic [ROW_W-1:0] zero_row,
  output logic [ROW_W-1:0] one_row
);
  localparam int unsigned NROWS = NDATA + 6;
  localparam int unsigned NSLOT = 1 << IDX_W;
  localparam int unsigned SCR1  = NDATA;
  localparam int unsigned SCR3  = NDATA + 2;
  localparam int unsigned ZROW  = NDATA + 3;
  localparam int unsigned OROW  = NDATA + 4;
  localparam int unsigned DROW  = NDATA + 5;

  logic [ROW_W-1:0] rows_w [NSLOT];
  logic [ROW_W-1:0] sensed;
  logic [ROW_W-1:0] r1, r2, r3;

  assign r1 = rows_w[SCR1];
  assign r2 = rows_w[SCR1 + 1];
  assign r3 = rows_w[SCR3];

  // sense amplifier value after the first activation
  always_comb begin
    if (prim_triple) sensed = (r1 & r2) | (r2 & r3) | (r1 & r3);
    else             sensed = rows_w[prim_src];
  end

  for (genvar r = 0; r < NSLOT; r++) begin : g_row
    if (r >= NROWS) begin : g_none
      assign rows_w[r] = '0;
    end else if (r == ZROW || r == OROW) begin : g_ctl
      logic [ROW_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= (r == OROW) ? '1 : '0;
      end
      assign rows_w[r] = q;
    end else begin : g_cell
      logic [ROW_W-1:0] q;
      logic hit_prim, hit_host;
      always_comb begin
        hit_prim = prim_valid &&
                   ((!prim_neg && prim_dst == IDX_W'(r)) ||
                    (prim_neg && r == DROW) ||
                    (prim_triple && r >= SCR1 && r <= SCR3));
        hit_host = wr_en && (wr_idx == IDX_W'(r)) && (r < NDATA);
      end
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (hit_prim) q <= prim_neg ? ~sensed : sensed;
        else if (hit_host) q <= wr_data;
      end
      assign rows_w[r] = q;
    end
  end

  assign rd_data  = rows_w[rd_idx];
  assign zero_row = rows_w[ZROW];
  assign one_row  = rows_w[OROW];
endmodule

// File: rtl/bulk_row_engine.sv
module bulk_row_engine #(
  parameter int unsigned ROW_W = 64,
  parameter int unsigned NDATA = 16,
  localparam int unsigned IDX_W = $clog2(NDATA + 6)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_src_a,
  input  logic [IDX_W-1:0] req_src_b,
  input  logic [IDX_W-1:0] req_dst,
  output logic             done,
  output logic             err,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ROW_W-1:0] rd_data
);
  logic             req_ok;
  logic             prim_valid, prim_triple, prim_neg;
  logic [IDX_W-1:0] prim_src, prim_dst;
  logic [ROW_W-1:0] zero_row_w, one_row_w;

  rowop_check #(.NDATA(NDATA), .IDX_W(IDX_W)) u_check (
    .op(req_op), .src_a(req_src_a), .src_b(req_src_b), .dst(req_dst), .ok(req_ok)
  );

  rowop_seq #(.NDATA(NDATA), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_dst(req_dst), .req_ok(req_ok), .prim_valid(prim_valid),
    .prim_triple(prim_triple), .prim_neg(prim_neg), .prim_src(prim_src),
    .prim_dst(prim_dst), .done(done), .err(err)
  );

  row_array #(.ROW_W(ROW_W), .NDATA(NDATA), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prim_valid(prim_valid),
    .prim_triple(prim_triple), .prim_neg(prim_neg), .prim_src(prim_src),
    .prim_dst(prim_dst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .zero_row(zero_row_w),
    .one_row(one_row_w)
  );
endmodule

// File: rtl/rowop_chk.sv
module rowop_chk #(
  parameter int unsigned ROW_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             done,
  input logic             err,
  input logic [ROW_W-1:0] zero_row,
  input logic [ROW_W-1:0] one_row
);
  // R11
  zero_row_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_row == '0);
  // R11
  one_row_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    one_row == '1);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!req_ready) && req_ready));
  // R10
  err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && $past(req_ready)));
  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind bulk_row_engine rowop_chk #(.ROW_W(ROW_W)) u_rowop_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .err(err),
  .zero_row(zero_row_w), .one_row(one_row_w)
);

// File: tb/test_bulk_row_engine.sv
`timescale 1ns/100ps
module test_bulk_row_engine;
  localparam int NDATA = 16;
  localparam int W = 64;
  localparam int S1 = NDATA, S2 = NDATA + 1, S3 = NDATA + 2;
  localparam int ZR = NDATA + 3, OR1 = NDATA + 4, DC = NDATA + 5;
  localparam int NV = 9;
  // {op[1:0], a[4:0], b[4:0], d[4:0]}
  localparam logic [16:0] VEC [NV] = '{
    {2'd0, 5'd3,  5'd0,  5'd5},
    {2'd1, 5'd1,  5'd2,  5'd7},
    {2'd2, 5'd4,  5'd6,  5'd8},
    {2'd3, 5'd9,  5'd0,  5'd10},
    {2'd1, 5'd5,  5'd7,  5'd0},
    {2'd0, 5'd20, 5'd0,  5'd11},
    {2'd2, 5'd19, 5'd12, 5'd13},
    {2'd3, 5'd21, 5'd0,  5'd14},
    {2'd1, 5'd16, 5'd15, 5'd15}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, done, err, wr_en = 0;
  logic [1:0] req_op = 0;
  logic [4:0] req_src_a = 0, req_src_b = 0, req_dst = 0, wr_idx = 0, rd_idx = 0;
  logic [W-1:0] wr_data = 0, rd_data;
  logic [W-1:0] mdl [32];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bulk_row_engine #(.ROW_W(W), .NDATA(NDATA)) i_bulk_row_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_src_a(req_src_a), .req_src_b(req_src_b),
    .req_dst(req_dst), .done(done), .err(err), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [W-1:0] v);
    rd_idx = 5'(idx);
    #0.5;
    v = rd_data;
  endtask

  task automatic hwrite(input int idx, input logic [W-1:0] v);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_data = v;
    @(posedge clk);
    #1 wr_en = 0;
    if (idx < NDATA) mdl[idx] = v;
  endtask

  // returns negedge count until done/err; k==1 is the cycle after acceptance
  task automatic issue(input logic [1:0] op, input int a, input int b, input int d,
                       output int k, output logic got_err, output logic rdy1);
    @(negedge clk);
    req_valid = 1; req_op = op;
    req_src_a = 5'(a); req_src_b = 5'(b); req_dst = 5'(d);
    @(posedge clk);
    #1 req_valid = 0;
    got_err = 0; rdy1 = 1; k = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) rdy1 = req_ready;
      if (done || err) begin
        k = i; got_err = err;
        break;
      end
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    pat = 64'h0F1E_2D3C_4B5A_6978 ^ {16{4'(i)}} ^ (64'hFFFF_0000_FF00_F0F0 >> i);
  endfunction

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [W-1:0] v, t;
    int k; logic e, r1;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mdl[OR1] = '1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v);   chk("R1 data row", v, '0);
    rd(S2, v);  chk("R1 scratch row", v, '0);
    rd(DC, v);  chk("R1 dual row", v, '0);
    rd(ZR, v);  chk("R1 zeros row", v, '0);
    rd(OR1, v); chk("R1 ones row", v, '1);
    chk("R1 ready/done/err", {61'd0, req_ready, done, err}, 64'h4);

    for (int i = 0; i < NDATA; i++) hwrite(i, pat(i));
    @(negedge clk);
    rd(6, v); chk("R2 host write", v, pat(6));

    for (int n = 0; n < NV; n++) begin
      logic [1:0] op; int a, b, d, lat;
      op = VEC[n][16:15]; a = int'(VEC[n][14:10]);
      b = int'(VEC[n][9:5]); d = int'(VEC[n][4:0]);
      case (op)
        2'd0: begin mdl[d] = mdl[a]; lat = 1; end
        2'd3: begin mdl[DC] = ~mdl[a]; mdl[d] = mdl[DC]; lat = 2; end
        default: begin
          mdl[S1] = mdl[a]; mdl[S2] = mdl[b];
          mdl[S3] = (op == 2'd1) ? '0 : '1;
          t = (mdl[S1] & mdl[S2]) | (mdl[S2] & mdl[S3]) | (mdl[S1] & mdl[S3]);
          mdl[S1] = t; mdl[S2] = t; mdl[S3] = t; mdl[d] = t;
          lat = 4;
        end
      endcase
      issue(op, a, b, d, k, e, r1);
      // R4 R5 R6 R8 latency; R9 done pulse seen
      chk($sformatf("R4 R5 R6 R8 latency vec%0d", n), 64'(k), 64'(lat + 1));
      chk($sformatf("R3 ready low vec%0d", n), {63'd0, r1}, 64'd0);
      chk($sformatf("R9 ready in done vec%0d", n), {63'd0, req_ready}, 64'd1);
      chk($sformatf("R10 no err vec%0d", n), {63'd0, e}, 64'd0);
      @(negedge clk);
      chk($sformatf("R9 done single vec%0d", n), {63'd0, done}, 64'd0);
      rd(d, v);
      chk($sformatf("R4 R5 R6 R8 result vec%0d", n), v, mdl[d]);
      if (op == 2'd1 || op == 2'd2) begin
        rd(S1, v); chk($sformatf("R7 scratch1 vec%0d", n), v, mdl[d]);
        rd(S3, v); chk($sformatf("R7 scratch3 vec%0d", n), v, mdl[d]);
      end
      if (op == 2'd3) begin
        rd(DC, v); chk($sformatf("R8 dual row vec%0d", n), v, mdl[DC]);
      end
    end

    // R10 rejected requests
    issue(2'd0, 3, 0, ZR, k, e, r1);
    chk("R10 err dst zeros", {62'd0, e, 1'b0} | 64'(k), 64'h3);
    rd(ZR, v); chk("R11 zeros row intact", v, '0);
    issue(2'd1, 2, 3, S1, k, e, r1);
    chk("R10 err dst scratch", {62'd0, e, 1'b0} | 64'(k), 64'h3);
    rd(S1, v); chk("R10 scratch untouched", v, mdl[S1]);
    issue(2'd3, 4, 0, DC, k, e, r1);
    chk("R10 err dst dual", {62'd0, e, 1'b0} | 64'(k), 64'h3);
    rd(DC, v); chk("R10 dual untouched", v, mdl[DC]);
    issue(2'd0, 23, 0, 2, k, e, r1);
    chk("R10 err src range", {62'd0, e, 1'b0} | 64'(k), 64'h3);
    rd(2, v); chk("R10 dst untouched", v, mdl[2]);
    @(negedge clk);
    chk("R10 err single", {63'd0, err}, 64'd0);

    // R2 host writes to non-data rows ignored, out-of-range read
    hwrite(OR1, 64'h0);
    hwrite(S2, 64'hDEAD_BEEF_0000_1111);
    @(negedge clk);
    rd(OR1, v); chk("R2 R11 ones write ignored", v, '1);
    rd(S2, v);  chk("R2 scratch write ignored", v, mdl[S2]);
    rd(27, v);  chk("R2 out of range read", v, '0);
    summary();
  end
endmodule